// File: doc/BRIEF.md
# Two-Wide Register Rename Unit

This block maps architectural register numbers to physical register numbers for a machine whose results live in one unified physical register file. Every cycle it can accept a group of two instructions. Each slot presents an opcode, a write flag, a destination and two source architectural registers. For each slot the block returns the physical tags of both sources, a freshly allocated physical destination and the physical register that the destination was mapped to before. The reorder buffer keeps that previous mapping and hands it back at commit, and the block then returns it to the pool of free registers.

The block holds the speculative mapping table, a circular queue of free physical register numbers, and one ready bit per physical register. Writeback sets the ready bit. A branch can save the current mapping and free-queue read position into a numbered checkpoint. On a mispredict, a restore request brings both back, which discards wrong-path mappings and reclaims their registers.

The second slot of a group may depend on the first. Its source tags and its previous-mapping output therefore take the first slot's new register where the architectural numbers match. If there are too few free registers for the whole group, nothing in the group is renamed.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register a maps to physical register a, every physical register is ready, and the free queue holds ARCH_REGS through PHYS_REGS-1 in ascending order, so the first two allocations are physical 8 and 9 with the default sizes (8 architectural, 16 physical).
- R2: In the same cycle as the request, each slot's source tag outputs show the table mapping of its source registers, and each slot's opcode appears unchanged on its opcode output.
- R3: On a granted group, a slot with its write flag set takes the next free-queue entry (slot 0 first, then slot 1), and from the next cycle on its destination maps to that register.
- R4: A writing slot's previous-mapping output shows the destination's mapping before the group. A slot with its write flag clear reports 0 for both the destination and the previous mapping, and it allocates nothing.
- R5: When slot 0 writes a register that slot 1 reads, slot 1's source tag is slot 0's new physical register and not the table value.
- R6: When both slots write the same architectural register, slot 1's previous mapping is slot 0's new register, and afterwards the table holds slot 1's register.
- R7: The grant output is low, and neither table nor free queue changes, when the request is not valid, a restore is present, or fewer registers are free than the group's writing slots.
- R8: A commit port returns a physical register to the tail of the free queue (port 0 ahead of port 1), and it is handed out again in queue order.
- R9: A freshly allocated register reads not-ready from the next cycle, a writeback makes it ready from the next cycle, and a slot 1 source bypassed from slot 0 always reads not-ready.
- R10: A save records the mapping and the free-queue read position as they stand after the same cycle's group. A later restore brings both back, so wrong-path mappings vanish and their registers are allocated again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ren_valid | input | 1 | Rename group present |
| ren_grant | output | 1 | Group renamed this cycle |
| s0_op | input | OP_W | Slot 0 opcode |
| s0_wr | input | 1 | Slot 0 writes a destination |
| s0_dst | input | AREG_W | Slot 0 destination register |
| s0_src_a | input | AREG_W | Slot 0 first source |
| s0_src_b | input | AREG_W | Slot 0 second source |
| s1_op | input | OP_W | Slot 1 opcode |
| s1_wr | input | 1 | Slot 1 writes a destination |
| s1_dst | input | AREG_W | Slot 1 destination register |
| s1_src_a | input | AREG_W | Slot 1 first source |
| s1_src_b | input | AREG_W | Slot 1 second source |
| s0_op_out | output | OP_W | Slot 0 opcode passed on |
| s0_psrc_a | output | PREG_W | Slot 0 first source tag |
| s0_psrc_b | output | PREG_W | Slot 0 second source tag |
| s0_rdy_a | output | 1 | Slot 0 first source ready |
| s0_rdy_b | output | 1 | Slot 0 second source ready |
| s0_pdst | output | PREG_W | Slot 0 new destination tag |
| s0_pold | output | PREG_W | Slot 0 previous destination mapping |
| s1_op_out | output | OP_W | Slot 1 opcode passed on |
| s1_psrc_a | output | PREG_W | Slot 1 first source tag |
| s1_psrc_b | output | PREG_W | Slot 1 second source tag |
| s1_rdy_a | output | 1 | Slot 1 first source ready |
| s1_rdy_b | output | 1 | Slot 1 second source ready |
| s1_pdst | output | PREG_W | Slot 1 new destination tag |
| s1_pold | output | PREG_W | Slot 1 previous destination mapping |
| cmt0_valid | input | 1 | Commit port 0 frees a register |
| cmt0_preg | input | PREG_W | Register freed by port 0 |
| cmt1_valid | input | 1 | Commit port 1 frees a register |
| cmt1_preg | input | PREG_W | Register freed by port 1 |
| wb_valid | input | 1 | Writeback present |
| wb_preg | input | PREG_W | Register written back |
| br_save | input | 1 | Save a checkpoint |
| br_save_id | input | CK_W | Checkpoint slot to save |
| br_restore | input | 1 | Restore a checkpoint |
| br_restore_id | input | CK_W | Checkpoint slot to restore |

## Verification
The tags, ready bits, grant and previous mappings are combinational on the request and are due in the same cycle. Table, free-queue, ready-bit and checkpoint updates take effect on the next rising edge and are seen by the group presented in the following cycle. The bench changes inputs on the falling edge and samples 1 ns later, before the next rising edge. A check of a state change is therefore always made one cycle after the stimulus that causes it, through the tags of a later group.

// File: rtl/rn_pkg.sv
package rn_pkg;
  localparam int ARCH_REGS = 8;
  localparam int PHYS_REGS = 16;
  localparam int CKPTS     = 2;
  localparam int OP_W      = 4;
  localparam int RD_PORTS  = 6;
  localparam int RDY_PORTS = 4;
  localparam int AREG_W    = $clog2(ARCH_REGS);
  localparam int PREG_W    = $clog2(PHYS_REGS);
  localparam int PTR_W     = PREG_W + 1;
  localparam int CK_W      = (CKPTS > 1) ? $clog2(CKPTS) : 1;
  localparam int INIT_FREE = PHYS_REGS - ARCH_REGS;

  typedef logic [AREG_W-1:0] areg_t;
  typedef logic [PREG_W-1:0] preg_t;
  typedef logic [PTR_W-1:0]  ptr_t;
  typedef logic [CK_W-1:0]   ckid_t;
  typedef logic [ARCH_REGS-1:0][PREG_W-1:0] rmap_t;

  typedef struct packed {
    logic  wr;
    areg_t dst;
    areg_t src_a;
    areg_t src_b;
  } slot_req_t;
endpackage

// File: rtl/rn_map_table.sv
module rn_map_table
  import rn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  areg_t rd_addr [RD_PORTS],
  output preg_t rd_data [RD_PORTS],
  input  logic  we0,
  input  areg_t wa0,
  input  preg_t wd0,
  input  logic  we1,
  input  areg_t wa1,
  input  preg_t wd1,
  input  logic  save,
  input  ckid_t save_id,
  input  logic  restore,
  input  ckid_t restore_id,
  output rmap_t map_q
);
  rmap_t map_d;
  rmap_t ckpt_q [CKPTS];
  logic  ckpt_en [CKPTS];

  function automatic rmap_t identity_map();
    rmap_t m;
    for (int a = 0; a < ARCH_REGS; a++) m[a] = preg_t'(a);
    return m;
  endfunction

  // later slot written last so it wins on equal destinations
  always_comb begin
    map_d = map_q;
    if (restore) begin
      map_d = ckpt_q[restore_id];
    end else begin
      if (we0) map_d[wa0] = wd0;
      if (we1) map_d[wa1] = wd1;
    end
  end

  always_comb begin
    for (int c = 0; c < CKPTS; c++)
      ckpt_en[c] = save && !restore && (save_id == ckid_t'(c));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      map_q <= identity_map();
      for (int c = 0; c < CKPTS; c++) ckpt_q[c] <= identity_map();
    end else begin
      map_q <= map_d;
      for (int c = 0; c < CKPTS; c++)
        if (ckpt_en[c]) ckpt_q[c] <= map_d;
    end
  end

  generate
    for (genvar r = 0; r < RD_PORTS; r++) begin : g_rd
      assign rd_data[r] = map_q[rd_addr[r]];
    end
  endgenerate
endmodule

// File: rtl/rn_free_list.sv
module rn_free_list
  import rn_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  pop0,
  input  logic  pop1,
  input  logic  push0,
  input  preg_t push0_preg,
  input  logic  push1,
  input  preg_t push1_preg,
  input  logic  save,
  input  ckid_t save_id,
  input  logic  restore,
  input  ckid_t restore_id,
  output preg_t alloc0,
  output preg_t alloc1,
  output ptr_t  free_cnt,
  output ptr_t  head_q
);
  preg_t fifo_q [PHYS_REGS];
  ptr_t  head_d, tail_q, tail_d;
  ptr_t  ckhead_q [CKPTS];
  preg_t h0_idx, h1_idx, t0_idx, t1_idx;

  always_comb begin
    h0_idx = head_q[PREG_W-1:0];
    h1_idx = h0_idx + preg_t'(1);
    t0_idx = tail_q[PREG_W-1:0];
    t1_idx = t0_idx + preg_t'(push0);
    alloc0 = fifo_q[h0_idx];
    alloc1 = pop0 ? fifo_q[h1_idx] : fifo_q[h0_idx];
    free_cnt = tail_q - head_q;
    head_d = restore ? ckhead_q[restore_id]
                     : head_q + ptr_t'(pop0) + ptr_t'(pop1);
    tail_d = tail_q + ptr_t'(push0) + ptr_t'(push1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= ptr_t'(INIT_FREE);
      for (int k = 0; k < PHYS_REGS; k++)
        fifo_q[k] <= (k < INIT_FREE) ? preg_t'(ARCH_REGS + k) : '0;
      for (int c = 0; c < CKPTS; c++) ckhead_q[c] <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      if (push0) fifo_q[t0_idx] <= push0_preg;
      if (push1) fifo_q[t1_idx] <= push1_preg;
      if (save && !restore) ckhead_q[save_id] <= head_d;
    end
  end
endmodule

// File: rtl/rn_ready_bits.sv
module rn_ready_bits
  import rn_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr0,
  input  preg_t                clr0_preg,
  input  logic                 clr1,
  input  preg_t                clr1_preg,
  input  logic                 set,
  input  preg_t                set_preg,
  input  preg_t                q_tag [RDY_PORTS],
  output logic                 q_rdy [RDY_PORTS],
  output logic [PHYS_REGS-1:0] rdy_q
);
  logic [PHYS_REGS-1:0] rdy_d;

  // allocation clears after writeback sets
  always_comb begin
    rdy_d = rdy_q;
    if (set)  rdy_d[set_preg]  = 1'b1;
    if (clr0) rdy_d[clr0_preg] = 1'b0;
    if (clr1) rdy_d[clr1_preg] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdy_q <= '1;
    else        rdy_q <= rdy_d;
  end

  generate
    for (genvar q = 0; q < RDY_PORTS; q++) begin : g_q
      assign q_rdy[q] = rdy_q[q_tag[q]];
    end
  endgenerate
endmodule

// File: rtl/rn_group_dep.sv
module rn_group_dep
  import rn_pkg::*;
(
  input  slot_req_t req0,
  input  slot_req_t req1,
  input  preg_t     tbl_a1,
  input  preg_t     tbl_b1,
  input  preg_t     tbl_old1,
  input  preg_t     new0,
  output preg_t     src_a1,
  output preg_t     src_b1,
  output preg_t     old1,
  output logic      hit_a1,
  output logic      hit_b1
);
  logic hit_d1;

  always_comb begin
    hit_a1 = req0.wr && (req0.dst == req1.src_a);
    hit_b1 = req0.wr && (req0.dst == req1.src_b);
    hit_d1 = req0.wr && req1.wr && (req0.dst == req1.dst);
    src_a1 = hit_a1 ? new0 : tbl_a1;
    src_b1 = hit_b1 ? new0 : tbl_b1;
    old1   = hit_d1 ? new0 : tbl_old1;
  end
endmodule

// File: rtl/rename_unit.sv
module rename_unit
  import rn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_valid,
  output logic              ren_grant,
  input  logic [OP_W-1:0]   s0_op,
  input  logic              s0_wr,
  input  logic [AREG_W-1:0] s0_dst,
  input  logic [AREG_W-1:0] s0_src_a,
  input  logic [AREG_W-1:0] s0_src_b,
  input  logic [OP_W-1:0]   s1_op,
  input  logic              s1_wr,
  input  logic [AREG_W-1:0] s1_dst,
  input  logic [AREG_W-1:0] s1_src_a,
  input  logic [AREG_W-1:0] s1_src_b,
  output logic [OP_W-1:0]   s0_op_out,
  output logic [PREG_W-1:0] s0_psrc_a,
  output logic [PREG_W-1:0] s0_psrc_b,
  output logic              s0_rdy_a,
  output logic              s0_rdy_b,
  output logic [PREG_W-1:0] s0_pdst,
  output logic [PREG_W-1:0] s0_pold,
  output logic [OP_W-1:0]   s1_op_out,
  output logic [PREG_W-1:0] s1_psrc_a,
  output logic [PREG_W-1:0] s1_psrc_b,
  output logic              s1_rdy_a,
  output logic              s1_rdy_b,
  output logic [PREG_W-1:0] s1_pdst,
  output logic [PREG_W-1:0] s1_pold,
  input  logic              cmt0_valid,
  input  logic [PREG_W-1:0] cmt0_preg,
  input  logic              cmt1_valid,
  input  logic [PREG_W-1:0] cmt1_preg,
  input  logic              wb_valid,
  input  logic [PREG_W-1:0] wb_preg,
  input  logic              br_save,
  input  logic [CK_W-1:0]   br_save_id,
  input  logic              br_restore,
  input  logic [CK_W-1:0]   br_restore_id
);
  slot_req_t req0, req1;
  areg_t     rd_addr [RD_PORTS];
  preg_t     rd_data [RD_PORTS];
  rmap_t     map_flat;
  preg_t     alloc0, alloc1;
  ptr_t      free_cnt, fl_head;
  logic [1:0] need;
  logic      pop0, pop1;
  preg_t     dep_a1, dep_b1, dep_old1;
  logic      hit_a1, hit_b1;
  preg_t     q_tag [RDY_PORTS];
  logic      q_rdy [RDY_PORTS];
  logic [PHYS_REGS-1:0] rdy_vec;

  assign req0 = '{wr: s0_wr, dst: s0_dst, src_a: s0_src_a, src_b: s0_src_b};
  assign req1 = '{wr: s1_wr, dst: s1_dst, src_a: s1_src_a, src_b: s1_src_b};

  assign rd_addr[0] = s0_src_a;
  assign rd_addr[1] = s0_src_b;
  assign rd_addr[2] = s0_dst;
  assign rd_addr[3] = s1_src_a;
  assign rd_addr[4] = s1_src_b;
  assign rd_addr[5] = s1_dst;

  // whole group or nothing
  always_comb begin
    need      = {1'b0, s0_wr} + {1'b0, s1_wr};
    ren_grant = ren_valid && !br_restore && (free_cnt >= ptr_t'(need));
    pop0      = ren_grant && s0_wr;
    pop1      = ren_grant && s1_wr;
  end

  rn_map_table u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_addr    (rd_addr),
    .rd_data    (rd_data),
    .we0        (pop0),
    .wa0        (s0_dst),
    .wd0        (alloc0),
    .we1        (pop1),
    .wa1        (s1_dst),
    .wd1        (alloc1),
    .save       (br_save),
    .save_id    (br_save_id),
    .restore    (br_restore),
    .restore_id (br_restore_id),
    .map_q      (map_flat)
  );

  rn_free_list u_free (
    .clk        (clk),
    .rst_n      (rst_n),
    .pop0       (pop0),
    .pop1       (pop1),
    .push0      (cmt0_valid),
    .push0_preg (cmt0_preg),
    .push1      (cmt1_valid),
    .push1_preg (cmt1_preg),
    .save       (br_save),
    .save_id    (br_save_id),
    .restore    (br_restore),
    .restore_id (br_restore_id),
    .alloc0     (alloc0),
    .alloc1     (alloc1),
    .free_cnt   (free_cnt),
    .head_q     (fl_head)
  );

  rn_group_dep u_dep (
    .req0     (req0),
    .req1     (req1),
    .tbl_a1   (rd_data[3]),
    .tbl_b1   (rd_data[4]),
    .tbl_old1 (rd_data[5]),
    .new0     (alloc0),
    .src_a1   (dep_a1),
    .src_b1   (dep_b1),
    .old1     (dep_old1),
    .hit_a1   (hit_a1),
    .hit_b1   (hit_b1)
  );

  assign q_tag[0] = rd_data[0];
  assign q_tag[1] = rd_data[1];
  assign q_tag[2] = rd_data[3];
  assign q_tag[3] = rd_data[4];

  rn_ready_bits u_rdy (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr0      (pop0),
    .clr0_preg (alloc0),
    .clr1      (pop1),
    .clr1_preg (alloc1),
    .set       (wb_valid),
    .set_preg  (wb_preg),
    .q_tag     (q_tag),
    .q_rdy     (q_rdy),
    .rdy_q     (rdy_vec)
  );

  always_comb begin
    s0_op_out = s0_op;
    s0_psrc_a = rd_data[0];
    s0_psrc_b = rd_data[1];
    s0_rdy_a  = q_rdy[0];
    s0_rdy_b  = q_rdy[1];
    s0_pdst   = s0_wr ? alloc0 : '0;
    s0_pold   = s0_wr ? rd_data[2] : '0;
    s1_op_out = s1_op;
    s1_psrc_a = dep_a1;
    s1_psrc_b = dep_b1;
    s1_rdy_a  = !hit_a1 && q_rdy[2];
    s1_rdy_b  = !hit_b1 && q_rdy[3];
    s1_pdst   = s1_wr ? alloc1 : '0;
    s1_pold   = s1_wr ? dep_old1 : '0;
  end
endmodule

// File: rtl/rn_checker.sv
module rn_checker
  import rn_pkg::*;
(
  input logic                 clk,
  input logic                 rst_n,
  input logic                 ren_grant,
  input logic                 br_restore,
  input logic                 s0_wr,
  input logic                 s1_wr,
  input areg_t                s1_dst,
  input preg_t                s0_pdst,
  input preg_t                s1_pdst,
  input ptr_t                 free_cnt,
  input ptr_t                 fl_head,
  input logic [PHYS_REGS-1:0] rdy_vec,
  input rmap_t                map_flat
);
  p_distinct_alloc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_grant && s0_wr && s1_wr) |-> (s0_pdst != s1_pdst));

  p_table_takes_slot1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_grant && s1_wr) |=> (map_flat[$past(s1_dst)] == $past(s1_pdst)));

  p_alloc_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_grant && s0_wr) |=> !rdy_vec[$past(s0_pdst)]);

  p_stall_holds_head_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!ren_grant && !br_restore) |=> $stable(fl_head));

  p_free_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= ptr_t'(INIT_FREE));
endmodule

bind rename_unit rn_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ren_grant  (ren_grant),
  .br_restore (br_restore),
  .s0_wr      (s0_wr),
  .s1_wr      (s1_wr),
  .s1_dst     (s1_dst),
  .s0_pdst    (s0_pdst),
  .s1_pdst    (s1_pdst),
  .free_cnt   (free_cnt),
  .fl_head    (fl_head),
  .rdy_vec    (rdy_vec),
  .map_flat   (map_flat)
);

// File: tb/sim_rename_unit.sv
`timescale 1ns/1ps
module sim_rename_unit;
  import rn_pkg::*;

  logic clk, rst_n, ren_valid, ren_grant;
  logic [OP_W-1:0] s0_op, s1_op, s0_op_out, s1_op_out;
  logic s0_wr, s1_wr;
  logic [AREG_W-1:0] s0_dst, s0_src_a, s0_src_b, s1_dst, s1_src_a, s1_src_b;
  logic [PREG_W-1:0] s0_psrc_a, s0_psrc_b, s0_pdst, s0_pold;
  logic [PREG_W-1:0] s1_psrc_a, s1_psrc_b, s1_pdst, s1_pold;
  logic s0_rdy_a, s0_rdy_b, s1_rdy_a, s1_rdy_b;
  logic cmt0_valid, cmt1_valid, wb_valid, br_save, br_restore;
  logic [PREG_W-1:0] cmt0_preg, cmt1_preg, wb_preg;
  logic [CK_W-1:0] br_save_id, br_restore_id;

  int checks = 0;
  int failures = 0;

  rename_unit u0 (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // {wr0,dst0,sa0,sb0, wr1,dst1,sa1,sb1, chk, grant, ps0a,ps0b,pd0,po0, ps1a,ps1b,pd1,po1}
  localparam int NV = 8;
  localparam logic [53:0] VEC [NV] = '{
    {1'b1,3'd1,3'd3,3'd2, 1'b1,3'd3,3'd1,3'd6, 1'b1,1'b1, 4'd3,4'd2,4'd8,4'd1,    4'd8,4'd6,4'd9,4'd3},
    {1'b1,3'd6,3'd7,3'd6, 1'b1,3'd3,3'd3,3'd6, 1'b1,1'b1, 4'd7,4'd6,4'd10,4'd6,   4'd9,4'd10,4'd11,4'd9},
    {1'b1,3'd6,3'd1,3'd1, 1'b1,3'd6,3'd6,3'd3, 1'b1,1'b1, 4'd8,4'd8,4'd12,4'd10,  4'd12,4'd11,4'd13,4'd12},
    {1'b0,3'd0,3'd6,3'd1, 1'b1,3'd2,3'd0,3'd5, 1'b1,1'b1, 4'd13,4'd8,4'd0,4'd0,   4'd0,4'd5,4'd14,4'd2},
    {1'b1,3'd5,3'd0,3'd0, 1'b1,3'd7,3'd0,3'd0, 1'b0,1'b0, 4'd0,4'd0,4'd0,4'd0,    4'd0,4'd0,4'd0,4'd0},
    {1'b1,3'd4,3'd2,3'd4, 1'b0,3'd0,3'd4,3'd2, 1'b1,1'b1, 4'd14,4'd4,4'd15,4'd4,  4'd15,4'd14,4'd0,4'd0},
    {1'b1,3'd7,3'd0,3'd0, 1'b0,3'd0,3'd0,3'd0, 1'b0,1'b0, 4'd0,4'd0,4'd0,4'd0,    4'd0,4'd0,4'd0,4'd0},
    {1'b0,3'd0,3'd1,3'd3, 1'b0,3'd0,3'd6,3'd4, 1'b1,1'b1, 4'd8,4'd11,4'd0,4'd0,   4'd13,4'd15,4'd0,4'd0}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic idle();
    ren_valid = 0; s0_op = 0; s1_op = 0;
    s0_wr = 0; s0_dst = 0; s0_src_a = 0; s0_src_b = 0;
    s1_wr = 0; s1_dst = 0; s1_src_a = 0; s1_src_b = 0;
    cmt0_valid = 0; cmt0_preg = 0; cmt1_valid = 0; cmt1_preg = 0;
    wb_valid = 0; wb_preg = 0;
    br_save = 0; br_save_id = 0; br_restore = 0; br_restore_id = 0;
  endtask

  task automatic grp(input logic v, input logic w0, input int d0, input int a0, input int b0,
                     input logic w1, input int d1, input int a1, input int b1);
    idle();
    ren_valid = v;
    s0_wr = w0; s0_dst = AREG_W'(d0); s0_src_a = AREG_W'(a0); s0_src_b = AREG_W'(b0);
    s1_wr = w1; s1_dst = AREG_W'(d1); s1_src_a = AREG_W'(a1); s1_src_b = AREG_W'(b1);
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    do_reset();

    // R1 reset state, R2 lookup and opcode pass-through
    grp(1, 0,0,5,7, 0,0,0,3);
    s0_op = 4'hA; s1_op = 4'h3;
    #1;
    chk("R1 reset map s0a", s0_psrc_a, 5);
    chk("R1 reset map s0b", s0_psrc_b, 7);
    chk("R1 reset map s1b", s1_psrc_b, 3);
    chk("R1 reset ready", {s0_rdy_a, s0_rdy_b, s1_rdy_a, s1_rdy_b}, 15);
    chk("R2 opcode s0", s0_op_out, 10);
    chk("R2 opcode s1", s1_op_out, 3);
    chk("R4 no write pdst", s0_pdst, 0);

    // vector walk: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NV; i++) begin
      logic [53:0] v;
      v = VEC[i];
      @(negedge clk);
      grp(1, v[53], v[52:50], v[49:47], v[46:44], v[43], v[42:40], v[39:37], v[36:34]);
      #1;
      chk($sformatf("R7 grant v%0d", i), ren_grant, v[32]);
      if (v[33]) begin
        chk($sformatf("R2 s0a v%0d", i), s0_psrc_a, v[31:28]);
        chk($sformatf("R2 s0b v%0d", i), s0_psrc_b, v[27:24]);
        chk($sformatf("R3 s0 pdst v%0d", i), s0_pdst, v[23:20]);
        chk($sformatf("R4 s0 pold v%0d", i), s0_pold, v[19:16]);
        chk($sformatf("R5 s1a v%0d", i), s1_psrc_a, v[15:12]);
        chk($sformatf("R5 s1b v%0d", i), s1_psrc_b, v[11:8]);
        chk($sformatf("R3 s1 pdst v%0d", i), s1_pdst, v[7:4]);
        chk($sformatf("R6 s1 pold v%0d", i), s1_pold, v[3:0]);
      end
    end

    // R9 ready bits: phys 8 (r1) and 14 (r2) allocated, not yet written back
    @(negedge clk);
    grp(1, 0,0,1,0, 0,0,2,3);
    #1;
    chk("R9 alloc busy s0a", s0_rdy_a, 0);
    chk("R9 untouched ready s0b", s0_rdy_b, 1);
    chk("R9 alloc busy s1a", s1_rdy_a, 0);
    @(negedge clk);
    idle(); wb_valid = 1; wb_preg = 4'd8;
    @(negedge clk);
    grp(1, 0,0,1,0, 0,0,0,0);
    #1;
    chk("R9 writeback ready", s0_rdy_a, 1);
    // R9 bypassed source is not ready
    @(negedge clk);
    grp(0, 1,5,0,0, 0,0,5,5);
    #1;
    chk("R9 bypass not ready", s1_rdy_a, 0);

    // R8 commit returns registers 1 then 3
    @(negedge clk);
    idle(); cmt0_valid = 1; cmt0_preg = 4'd1; cmt1_valid = 1; cmt1_preg = 4'd3;
    @(negedge clk);
    grp(0, 1,5,0,0, 1,7,0,0);
    #1;
    chk("R7 invalid no grant", ren_grant, 0);
    @(negedge clk);
    grp(1, 1,5,0,0, 1,7,0,0);
    #1;
    chk("R8 grant after commit", ren_grant, 1);
    chk("R8 reuse order s0", s0_pdst, 1);
    chk("R8 reuse order s1", s1_pdst, 3);
    chk("R4 pold s0", s0_pold, 5);
    @(negedge clk);
    grp(1, 0,0,5,7, 0,0,0,0);
    #1;
    chk("R3 map r5", s0_psrc_a, 1);
    chk("R3 map r7", s0_psrc_b, 3);
    chk("R9 new reg busy", s0_rdy_a, 0);

    // R10 checkpoint and restore
    do_reset();
    grp(1, 1,1,0,0, 0,0,0,0);
    br_save = 1; br_save_id = 1;
    #1;
    chk("R10 pre-save alloc", s0_pdst, 8);
    @(negedge clk);
    grp(1, 1,1,0,0, 1,2,0,0);
    #1;
    chk("R10 wrong path s0", s0_pdst, 9);
    chk("R10 wrong path pold", s0_pold, 8);
    chk("R10 wrong path s1", s1_pdst, 10);
    @(negedge clk);
    grp(1, 1,3,0,0, 0,0,0,0);
    br_restore = 1; br_restore_id = 1;
    #1;
    chk("R10 restore blocks grant", ren_grant, 0);
    @(negedge clk);
    grp(1, 1,2,1,2, 0,0,0,0);
    #1;
    chk("R10 restored map r1", s0_psrc_a, 8);
    chk("R10 restored map r2", s0_psrc_b, 2);
    chk("R10 reclaimed reg", s0_pdst, 9);
    chk("R10 restored pold", s0_pold, 2);

    @(negedge clk);
    idle();
    @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule